// File: doc/BRIEF.md
# Nibble-Wide Clock Chip Bridge for a Dynamically Sized 16-bit Bus

This block sits between a 16-bit processor bus that supports dynamic bus sizing and a real-time clock chip with a 4-bit data port and a 4-bit register address. The block decodes a 2 KiB window at offset 0x2000 inside one chip-select region. It drives the clock chip's active-low select and read and write strobes. It also produces the chip's active-high enable, which is taken directly from the system reset. This keeps the chip shut off while reset is asserted and during power-up.

The clock chip's nibble travels on bus data bits 11:8, which is the upper byte lane. A single byte access therefore returns the register value directly. The register address is taken from bus address bits 3:0 with no shift. Because of this, consecutive byte offsets reach consecutive registers. After a fixed number of clocks the block acknowledges with the 8-bit port acknowledge only. This makes the processor resize the cycle to one byte.

The bus side uses a strobe/acknowledge handshake, not valid/ready. Back-pressure comes only from the acknowledge delay: the processor holds its address and strobes until it sees the acknowledge. It then releases the address strobe, which removes the acknowledge at once.

Top module: `nibble_rtc_bridge`

## Requirements
- R1: `rtc_sel_n` is low exactly when `cs_n` and `as_n` are both low and the region offset `addr` lies in 0x2000..0x27FF. Every address bit above bit 10 takes part in the compare.
- R2: `rtc_en` is high exactly when `rst_n` is high.
- R3: During a read in the window with `rtc_en` high, `rtc_rd_n` is low, `dat_oe` equals 0x0F00 and `dat_out[11:8]` equals `rtc_dq_in`.
- R4: Bus data bits 15:12 and 7:0 are never driven: those bits of `dat_oe` are always 0.
- R5: `rtc_addr` equals `addr[3:0]`, so odd byte offsets select odd clock registers.
- R6: When an in-window access is enabled, `dsack0_n` stays high until `ACK_DELAY` rising clock edges (default 3) have been seen with the select active. It goes low after that edge.
- R7: `dsack0_n` is high whenever `as_n` is high, in the same cycle, without waiting for a clock edge. An access aborted before the delay expires restarts the count on the next access.
- R8: An access outside the window never drives `rtc_sel_n` or `dsack0_n` low, and a write outside the window leaves the clock registers unchanged.
- R9: During a write in the window (`rw` = 0) with `ds_n` low and `rtc_en` high, `rtc_wr_n` is low and `rtc_dq_out` equals `dat_in[11:8]`. The clock chip latches on the rising edge of `rtc_wr_n`, and bits 15:12 and 7:0 of the written word are ignored.
- R10: While `rst_n` is low, `rtc_rd_n`, `rtc_wr_n` and `dsack0_n` stay high and `dat_oe` stays 0, even for an in-window access.
- R11: During a write cycle `dat_oe` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Bus clock |
| rst_n | input | 1 | Active-low system reset |
| cs_n | input | 1 | Active-low chip-select region strobe |
| as_n | input | 1 | Active-low address strobe |
| ds_n | input | 1 | Active-low data strobe for the upper byte |
| rw | input | 1 | 1 = read, 0 = write |
| addr | input | 19 | Byte offset inside the chip-select region |
| dat_in | input | 16 | Bus write data |
| dat_out | output | 16 | Bus read data |
| dat_oe | output | 16 | Per-bit drive enable for the bus data |
| dsack0_n | output | 1 | Active-low 8-bit port acknowledge |
| rtc_sel_n | output | 1 | Active-low clock chip select |
| rtc_en | output | 1 | Active-high clock chip enable |
| rtc_addr | output | 4 | Clock register address |
| rtc_rd_n | output | 1 | Active-low read strobe to the clock chip |
| rtc_wr_n | output | 1 | Active-low write strobe to the clock chip |
| rtc_dq_out | output | 4 | Nibble written to the clock chip |
| rtc_dq_in | input | 4 | Nibble read from the clock chip |

## Verification
Some checks run on every cycle. These cover the select requiring both strobes, the direct register address and the lane placement of read data. They also cover the rule that the outer lanes are never driven, and the write strobe's qualification. The acknowledge is checked against a window counter so that it can be neither early nor late, and it must fall immediately when the address strobe is released. Other behaviour shows only in the bench's scenarios, read back through the bus. These are: out-of-window writes leaving the register contents alone, discarded outer-lane write bits, the count restarting after an aborted access, and silence during reset.

// File: rtl/nibble_rtc_bridge_pkg.sv
package nibble_rtc_bridge_pkg;

  // Decoded intent of the current bus cycle toward the clock chip.
  typedef struct packed {
    logic hit;   // address window and strobes match
    logic rd;    // enabled read
    logic wr;    // enabled, data-strobed write
  } rtcb_req_t;

  // Width of a counter that must reach the value n.
  function automatic int unsigned cnt_width(input int unsigned n);
    return (n < 2) ? 1 : $clog2(n + 1);
  endfunction

endpackage

// File: rtl/rtcb_window.sv
module rtcb_window #(
  parameter int unsigned ADDR_W   = 19,
  parameter int unsigned WIN_BASE = 'h2000,
  parameter int unsigned WIN_LOG2 = 11
) (
  input  logic              cs_n,
  input  logic              as_n,
  input  logic [ADDR_W-1:0] addr,
  output logic              hit
);
  localparam int unsigned TAG_W = ADDR_W - WIN_LOG2;
  localparam logic [TAG_W-1:0] TAG = TAG_W'(WIN_BASE >> WIN_LOG2);

  logic [TAG_W-1:0] tag;
  assign tag = addr[ADDR_W-1:WIN_LOG2];
  assign hit = !cs_n && !as_n && (tag == TAG);
endmodule

// File: rtl/rtcb_ack_timer.sv
module rtcb_ack_timer
  import nibble_rtc_bridge_pkg::*;
#(
  parameter int unsigned ACK_DELAY = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  output logic ack_n
);
  localparam int unsigned CW = cnt_width(ACK_DELAY);
  localparam logic [CW-1:0] LIMIT = CW'(ACK_DELAY);

  logic [CW-1:0] cnt_q;
  logic          done;

  assign done = (cnt_q == LIMIT);

  // Counts edges seen with the select active; cleared as soon as it drops.
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       cnt_q <= '0;
    else if (!active) cnt_q <= '0;
    else if (!done)   cnt_q <= cnt_q + 1'b1;
  end

  // Combinational gate on active so release of the strobe ends the ack at once.
  assign ack_n = !(active && done);
endmodule

// File: rtl/rtcb_lanes.sv
module rtcb_lanes #(
  parameter int unsigned BUS_W    = 16,
  parameter int unsigned RTC_DW   = 4,
  parameter int unsigned LANE_LSB = 8
) (
  input  logic              rd,
  input  logic [BUS_W-1:0]  dat_in,
  input  logic [RTC_DW-1:0] rtc_dq_in,
  output logic [BUS_W-1:0]  dat_out,
  output logic [BUS_W-1:0]  dat_oe,
  output logic [RTC_DW-1:0] rtc_dq_out
);
  localparam int unsigned LANE_MSB = LANE_LSB + RTC_DW - 1;

  assign rtc_dq_out = dat_in[LANE_MSB:LANE_LSB];

  for (genvar b = 0; b < BUS_W; b++) begin : g_bit
    if (b >= LANE_LSB && b <= LANE_MSB) begin : g_lane
      assign dat_out[b] = rd & rtc_dq_in[b - LANE_LSB];
      assign dat_oe[b]  = rd;
    end else begin : g_quiet
      assign dat_out[b] = 1'b0;
      assign dat_oe[b]  = 1'b0;
    end
  end
endmodule

// File: rtl/nibble_rtc_bridge.sv
module nibble_rtc_bridge
  import nibble_rtc_bridge_pkg::*;
#(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned BUS_W     = 16,
  parameter int unsigned RTC_DW    = 4,
  parameter int unsigned RTC_AW    = 4,
  parameter int unsigned LANE_LSB  = 8,
  parameter int unsigned WIN_BASE  = 'h2000,
  parameter int unsigned WIN_LOG2  = 11,
  parameter int unsigned ACK_DELAY = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              as_n,
  input  logic              ds_n,
  input  logic              rw,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BUS_W-1:0]  dat_in,
  output logic [BUS_W-1:0]  dat_out,
  output logic [BUS_W-1:0]  dat_oe,
  output logic              dsack0_n,
  output logic              rtc_sel_n,
  output logic              rtc_en,
  output logic [RTC_AW-1:0] rtc_addr,
  output logic              rtc_rd_n,
  output logic              rtc_wr_n,
  output logic [RTC_DW-1:0] rtc_dq_out,
  input  logic [RTC_DW-1:0] rtc_dq_in
);
  rtcb_req_t req;
  logic      hit;

  rtcb_window #(.ADDR_W(ADDR_W), .WIN_BASE(WIN_BASE), .WIN_LOG2(WIN_LOG2)) u_win (
    .cs_n(cs_n), .as_n(as_n), .addr(addr), .hit(hit)
  );

  // The second enable is reset itself: no access can reach the chip in reset.
  assign rtc_en = rst_n;

  always_comb begin
    req.hit = hit;
    req.rd  = hit && rtc_en && rw;
    req.wr  = hit && rtc_en && !rw && !ds_n;
  end

  assign rtc_sel_n = !req.hit;
  assign rtc_rd_n  = !req.rd;
  assign rtc_wr_n  = !req.wr;
  assign rtc_addr  = addr[RTC_AW-1:0];

  rtcb_ack_timer #(.ACK_DELAY(ACK_DELAY)) u_ack (
    .clk(clk), .rst_n(rst_n), .active(req.hit && rtc_en), .ack_n(dsack0_n)
  );

  rtcb_lanes #(.BUS_W(BUS_W), .RTC_DW(RTC_DW), .LANE_LSB(LANE_LSB)) u_lanes (
    .rd(req.rd), .dat_in(dat_in), .rtc_dq_in(rtc_dq_in),
    .dat_out(dat_out), .dat_oe(dat_oe), .rtc_dq_out(rtc_dq_out)
  );
endmodule

// File: rtl/nibble_rtc_bridge_chk.sv
module nibble_rtc_bridge_chk #(
  parameter int unsigned ADDR_W    = 19,
  parameter int unsigned BUS_W     = 16,
  parameter int unsigned RTC_DW    = 4,
  parameter int unsigned RTC_AW    = 4,
  parameter int unsigned LANE_LSB  = 8,
  parameter int unsigned ACK_DELAY = 3
) (
  input logic              clk,
  input logic              rst_n,
  input logic              cs_n,
  input logic              as_n,
  input logic              ds_n,
  input logic              rw,
  input logic [ADDR_W-1:0] addr,
  input logic [BUS_W-1:0]  dat_in,
  input logic [BUS_W-1:0]  dat_out,
  input logic [BUS_W-1:0]  dat_oe,
  input logic              dsack0_n,
  input logic              rtc_sel_n,
  input logic              rtc_en,
  input logic [RTC_AW-1:0] rtc_addr,
  input logic              rtc_rd_n,
  input logic              rtc_wr_n,
  input logic [RTC_DW-1:0] rtc_dq_out,
  input logic [RTC_DW-1:0] rtc_dq_in
);
  localparam int unsigned LANE_MSB = LANE_LSB + RTC_DW - 1;
  localparam logic [BUS_W-1:0] LANE_MASK = BUS_W'(((1 << RTC_DW) - 1) << LANE_LSB);

  // Window counter: edges seen with an enabled select, saturating.
  int unsigned win_cnt;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                          win_cnt <= 0;
    else if (rtc_sel_n || !rtc_en)       win_cnt <= 0;
    else if (win_cnt < ACK_DELAY)        win_cnt <= win_cnt + 1;
  end

  a_r1_sel_needs_strobes: assert property (@(posedge clk) disable iff (!rst_n)
    !rtc_sel_n |-> (!cs_n && !as_n));
  a_r3_read_lane: assert property (@(posedge clk) disable iff (!rst_n)
    !rtc_rd_n |-> (dat_out[LANE_MSB:LANE_LSB] == rtc_dq_in && dat_oe == LANE_MASK));
  a_r4_outer_lanes_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    (dat_oe & ~LANE_MASK) == '0);
  a_r5_addr_direct: assert property (@(posedge clk) disable iff (!rst_n)
    !rtc_sel_n |-> rtc_addr == addr[RTC_AW-1:0]);
  a_r6_ack_not_early: assert property (@(posedge clk) disable iff (!rst_n)
    !dsack0_n |-> win_cnt >= ACK_DELAY);
  a_r6_ack_on_time: assert property (@(posedge clk) disable iff (!rst_n)
    (win_cnt >= ACK_DELAY && !rtc_sel_n) |-> !dsack0_n);
  a_r7_strobe_drops_ack: assert property (@(posedge clk) disable iff (!rst_n)
    as_n |-> dsack0_n);
  a_r8_no_ack_outside: assert property (@(posedge clk) disable iff (!rst_n)
    rtc_sel_n |-> dsack0_n);
  a_r9_write_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    !rtc_wr_n |-> (!rw && !ds_n && !rtc_sel_n && rtc_dq_out == dat_in[LANE_MSB:LANE_LSB]));
  a_r11_no_drive_on_write: assert property (@(posedge clk) disable iff (!rst_n)
    !rw |-> dat_oe == '0);
endmodule

bind nibble_rtc_bridge nibble_rtc_bridge_chk #(
  .ADDR_W(ADDR_W), .BUS_W(BUS_W), .RTC_DW(RTC_DW), .RTC_AW(RTC_AW),
  .LANE_LSB(LANE_LSB), .ACK_DELAY(ACK_DELAY)
) u_chk (.*);

// File: tb/nibble_rtc_bridge_test.sv
`timescale 1ns/100ps
module nibble_rtc_bridge_test;
  localparam int DLY = 3;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cs_n = 1'b1, as_n = 1'b1, ds_n = 1'b1, rw = 1'b1;
  logic [18:0] addr = '0;
  logic [15:0] dat_in = '0;
  logic [15:0] dat_out, dat_oe;
  logic        dsack0_n, rtc_sel_n, rtc_en, rtc_rd_n, rtc_wr_n;
  logic [3:0]  rtc_addr, rtc_dq_out, rtc_dq_in;

  int checks = 0, fails = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  nibble_rtc_bridge #(.ACK_DELAY(DLY)) uut (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .as_n(as_n), .ds_n(ds_n), .rw(rw),
    .addr(addr), .dat_in(dat_in), .dat_out(dat_out), .dat_oe(dat_oe),
    .dsack0_n(dsack0_n), .rtc_sel_n(rtc_sel_n), .rtc_en(rtc_en),
    .rtc_addr(rtc_addr), .rtc_rd_n(rtc_rd_n), .rtc_wr_n(rtc_wr_n),
    .rtc_dq_out(rtc_dq_out), .rtc_dq_in(rtc_dq_in)
  );

  // Behavioural clock chip register file.
  logic [3:0] rtc_mem [16];
  logic [3:0] shadow  [16];
  assign rtc_dq_in = !rtc_rd_n ? rtc_mem[rtc_addr] : 4'h0;
  always @(posedge rtc_wr_n) if (rst_n === 1'b1 && rtc_en === 1'b1) rtc_mem[rtc_addr] <= rtc_dq_out;

  task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  // One bus cycle; lat = edge count until ack (0 = none in 8 edges).
  task automatic bus_cycle(input logic [18:0] a, input logic r, input logic [15:0] wd,
                           output int lat, output logic [15:0] rdo, output logic [15:0] oe,
                           output logic sel, output logic early, output logic after);
    @(negedge clk);
    addr = a; rw = r; dat_in = wd; cs_n = 1'b0; as_n = 1'b0; ds_n = 1'b0;
    #1;
    sel = !rtc_sel_n; early = !dsack0_n; rdo = dat_out; oe = dat_oe; lat = 0;
    for (int k = 1; k <= 8 && lat == 0; k++) begin
      @(posedge clk); #1;
      if (!dsack0_n) begin lat = k; rdo = dat_out; oe = dat_oe; end
    end
    @(negedge clk);
    #0.5 ds_n = 1'b1;
    #0.5 as_n = 1'b1; cs_n = 1'b1;
    #0.5 after = !dsack0_n;
  endtask

  typedef struct packed {
    logic [18:0] a;
    logic        r;
    logic [15:0] wd;
    logic        hit;
  } vec_t;

  localparam vec_t VECS [12] = '{
    '{19'h02000, 1'b0, 16'hF5AA, 1'b1},
    '{19'h02003, 1'b0, 16'h0C00, 1'b1},
    '{19'h02003, 1'b1, 16'h0000, 1'b1},
    '{19'h02000, 1'b1, 16'h0000, 1'b1},
    '{19'h027FF, 1'b0, 16'h3955, 1'b1},
    '{19'h027FF, 1'b1, 16'h0000, 1'b1},
    '{19'h01FFF, 1'b1, 16'h0000, 1'b0},
    '{19'h02800, 1'b0, 16'h0E00, 1'b0},
    '{19'h02000, 1'b1, 16'h0000, 1'b1},
    '{19'h42000, 1'b1, 16'h0000, 1'b0},
    '{19'h02001, 1'b0, 16'hA7FF, 1'b1},
    '{19'h02001, 1'b1, 16'h0000, 1'b1}
  };

  initial begin
    #100000;
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual %0h expected %0h", 0, 1);
      $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
      $finish;
    end
  end

  initial begin
    int lat;
    logic [15:0] rdo, oe;
    logic sel, early, after;
    for (int i = 0; i < 16; i++) begin rtc_mem[i] = 4'h0; shadow[i] = 4'h0; end

    // Reset state and an in-window read attempted during reset (R2, R10).
    repeat (2) @(negedge clk);
    #1;
    check(rtc_en == 1'b0, "R2 enable low in reset", 32'(rtc_en), 0);
    check(dsack0_n == 1'b1, "R10 no ack in reset", 32'(dsack0_n), 1);
    @(negedge clk);
    addr = 19'h02000; rw = 1'b1; cs_n = 1'b0; as_n = 1'b0; ds_n = 1'b0;
    repeat (5) @(posedge clk);
    #1;
    check(dsack0_n == 1'b1, "R10 ack held off in reset", 32'(dsack0_n), 1);
    check(rtc_rd_n == 1'b1, "R10 read strobe held off", 32'(rtc_rd_n), 1);
    check(dat_oe == 16'h0, "R10 bus not driven in reset", 32'(dat_oe), 0);
    @(negedge clk);
    cs_n = 1'b1; as_n = 1'b1; ds_n = 1'b1;
    @(negedge clk);
    rst_n = 1'b1;
    #1;
    check(rtc_en == 1'b1, "R2 enable follows reset release", 32'(rtc_en), 1);

    // Vector table walk (R1, R3, R4, R5, R6, R7, R8, R9, R11).
    foreach (VECS[i]) begin
      bus_cycle(VECS[i].a, VECS[i].r, VECS[i].wd, lat, rdo, oe, sel, early, after);
      check(sel == VECS[i].hit, "R1 select decode", 32'(sel), 32'(VECS[i].hit));
      check(early == 1'b0, "R6 no ack before first edge", 32'(early), 0);
      check(after == 1'b0, "R7 ack removed with strobe", 32'(after), 0);
      if (VECS[i].hit) begin
        check(lat == DLY, "R6 ack latency", 32'(lat), DLY);
        if (VECS[i].r) begin
          check(oe == 16'h0F00, "R4 only lane 11:8 driven", 32'(oe), 32'h0F00);
          check(rdo[11:8] == shadow[VECS[i].a[3:0]], "R3 R5 read nibble",
                32'(rdo[11:8]), 32'(shadow[VECS[i].a[3:0]]));
        end else begin
          check(oe == 16'h0, "R11 no drive on write", 32'(oe), 0);
          shadow[VECS[i].a[3:0]] = VECS[i].wd[11:8];   // R9 only bits 11:8 land
        end
      end else begin
        check(lat == 0, "R8 no ack outside window", 32'(lat), 0);
        check(oe == 16'h0, "R8 no drive outside window", 32'(oe), 0);
      end
    end

    // R1: window address with chip select inactive.
    @(negedge clk);
    addr = 19'h02004; rw = 1'b1; cs_n = 1'b1; as_n = 1'b0; ds_n = 1'b0;
    #1;
    check(rtc_sel_n == 1'b1, "R1 no select without cs", 32'(rtc_sel_n), 1);
    @(negedge clk);
    as_n = 1'b1; ds_n = 1'b1;

    // R7: abort after one edge, then a fresh access must take the full delay.
    @(negedge clk);
    addr = 19'h02003; rw = 1'b1; cs_n = 1'b0; as_n = 1'b0; ds_n = 1'b0;
    @(posedge clk); #1;
    check(dsack0_n == 1'b1, "R7 no ack after one edge", 32'(dsack0_n), 1);
    @(negedge clk);
    cs_n = 1'b1; as_n = 1'b1; ds_n = 1'b1;
    bus_cycle(19'h02003, 1'b1, 16'h0, lat, rdo, oe, sel, early, after);
    check(lat == DLY, "R7 count restarts after abort", 32'(lat), DLY);

    // R9: write without data strobe leaves the register unchanged.
    @(negedge clk);
    addr = 19'h02003; rw = 1'b0; dat_in = 16'h0600; cs_n = 1'b0; as_n = 1'b0; ds_n = 1'b1;
    repeat (DLY + 1) @(posedge clk);
    #1;
    check(rtc_wr_n == 1'b1, "R9 no write strobe without ds", 32'(rtc_wr_n), 1);
    @(negedge clk);
    cs_n = 1'b1; as_n = 1'b1;
    bus_cycle(19'h02003, 1'b1, 16'h0, lat, rdo, oe, sel, early, after);
    check(rdo[11:8] == shadow[3], "R9 register kept", 32'(rdo[11:8]), 32'(shadow[3]));

    done = 1'b1;
    $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  end
endmodule